// File: doc/BRIEF.md
# Field Acknowledge Decision Unit

This block sits beside the receive datapath of a slave on a half-duplex serial bus shared by several masters. At the end of every frame field the bit-level receiver presents one strobe that carries the field type, the received bits and the received parity bit. The field is one of three kinds: the 4-bit command code, the message length or one data byte. From that strobe the unit decides whether the slave answers ACK or NAK. It also decides whether the transfer must stop.

The decision uses several inputs. It checks even parity. It looks for timing faults reported since the previous acknowledge. It reads the occupancy flags of the receive and transmit buffers. It compares the lock held on this slave with the master now talking. For data bytes it counts the bytes of the current frame against a per-frame budget. A byte that is refused because of bad parity or a full buffer can then be sent again without tearing the transfer down. The answer comes out one clock after the strobe, together with a one-clock abort pulse when the transfer ends.

Top module: `field_ack_unit`

## Requirements
- R1: The answer is registered. A strobe with field kind 0 (command), 1 (length) or 2 (data) raises `ack_vld` for exactly the next clock, with `ack_ok` = 1 for ACK and 0 for NAK. A strobe with kind 3 produces no answer. After reset `ack_vld`, `ack_ok` and `abort` are 0.
- R2: Parity is even over the field bits plus `fld_par`. An odd count of ones gives NAK in any field. For a command or length field the NAK also aborts.
- R3: A command code with bit 3 set is a write. It is NAKed while `rx_empty` is 0.
- R4: Codes 0x3 and 0x7 are reads. They are NAKed while `tx_empty` is 1. No other code looks at `tx_empty`.
- R5: While `locked` is 1 and `cur_master` differs from `lock_owner`, the codes 0x3, 0x6, 0x7, 0xA, 0xB, 0xE and 0xF are NAKed. If the current master is the lock owner, or the code is outside that set, the lock refuses nothing.
- R6: Codes 0x4 and 0x5 are NAKed while `locked` is 0. When the slave is locked they are accepted from any master.
- R7: Codes 0x1, 0x2, 0x8, 0x9, 0xC and 0xD are undefined and always NAKed. The code 0x0 with good parity and no other fault is ACKed.
- R8: A `tim_err` pulse is remembered until the next answered strobe. A pulse in the strobe cycle also counts. Either one makes that field NAK and abort, whatever its kind, and the memory is then cleared.
- R9: A length field is NAKed only on a parity or timing fault. The buffer flags and the lock state have no effect on it.
- R10: A data byte is NAKed while `rx_full` is 1.
- R11: Every data strobe counts one byte of the frame. A command strobe resets the count to zero. A data NAK caused only by parity or a full buffer does not abort while the count, including this byte, is below `MAX_BYTES`. Once the count reaches `MAX_BYTES`, such a NAK aborts.
- R12: `abort` is a single-clock pulse. It comes only together with a NAK, and it is never raised with an ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fld_vld | input | 1 | One-cycle end-of-field strobe |
| fld_kind | input | 2 | 0 command, 1 length, 2 data, 3 none |
| fld_bits | input | DATA_W | Received field bits; the command code uses bits 3:0 |
| fld_par | input | 1 | Received parity bit |
| tim_err | input | 1 | Timing fault pulse from the bit receiver |
| rx_empty | input | 1 | Slave receive buffer is empty |
| rx_full | input | 1 | Slave receive buffer cannot take another byte |
| tx_empty | input | 1 | Slave transmit buffer is empty |
| locked | input | 1 | Slave is locked by a master |
| lock_owner | input | ID_W | Identity of the locking master |
| cur_master | input | ID_W | Identity of the master of the present frame |
| ack_vld | output | 1 | Answer valid, one clock after the strobe |
| ack_ok | output | 1 | 1 = ACK, 0 = NAK |
| abort | output | 1 | One-clock transfer-stop pulse |

## Verification
The bench builds the unit with `MAX_BYTES` = 4 and `ID_W` = 3. With a budget of four bytes, the repeat window can be crossed in a few strobes: three refused bytes pass without abort and the fourth stops the transfer. The count is also seen to saturate and to restart after a command field. The 3-bit master identities are enough to pair matching and differing owners against every code in the lock-protected set.

// File: rtl/field_ack_pkg.sv
package field_ack_pkg;
  typedef enum logic [1:0] {
    FK_CMD  = 2'd0,
    FK_LEN  = 2'd1,
    FK_DATA = 2'd2,
    FK_NONE = 2'd3
  } fkind_e;

  localparam int CODE_W = 4;
  localparam int CODES  = 1 << CODE_W;

  // one bit per command code, bit n stands for code n
  localparam logic [CODES-1:0] CODE_DEFINED = 16'hCCF9;
  localparam logic [CODES-1:0] CODE_LOCKSET = 16'hCCC8;
  localparam logic [CODES-1:0] CODE_READ    = 16'h0088;
  localparam logic [CODES-1:0] CODE_LOCKRD  = 16'h0030;
endpackage

// File: rtl/field_parity.sv
module field_parity #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits,
  input  logic         par,
  output logic         bad
);
  // even parity: odd total count of ones is a failure
  assign bad = ^{bits, par};
endmodule

// File: rtl/cmd_judge.sv
module cmd_judge
  import field_ack_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic [CODE_W-1:0] code,
  input  logic              rx_empty,
  input  logic              tx_empty,
  input  logic              locked,
  input  logic [ID_W-1:0]   lock_owner,
  input  logic [ID_W-1:0]   cur_master,
  output logic              reject
);
  logic             foreign;
  logic [CODES-1:0] rej_v;

  assign foreign = locked && (lock_owner != cur_master);

  for (genvar g = 0; g < CODES; g++) begin : g_code
    localparam logic [CODE_W-1:0] C = CODE_W'(g);
    assign rej_v[g] = !CODE_DEFINED[g]
                    || (C[CODE_W-1] && !rx_empty)
                    || (CODE_READ[g] && tx_empty)
                    || (CODE_LOCKSET[g] && foreign)
                    || (CODE_LOCKRD[g] && !locked);
  end

  assign reject = rej_v[code];

  always_comb begin
    a_r7_undefined_refused : assert (CODE_DEFINED[code] || reject);
  end
endmodule

// File: rtl/byte_budget.sv
module byte_budget #(
  parameter int MAX_BYTES = 32,
  localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
  input  logic clk,
  input  logic rst_q,
  input  logic clr,
  input  logic inc,
  output logic room
);
  localparam logic [CNT_W:0]   MAXV = (CNT_W + 1)'(MAX_BYTES);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_BYTES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign room = ({1'b0, cnt_q} + 1'b1) < MAXV;

  always_comb begin
    cnt_en = clr || (inc && (cnt_q != MAXC));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  a_r11_count_bounded : assert property (@(posedge clk) disable iff (!rst_q)
    cnt_q <= MAXC);
  a_r11_clear_resets : assert property (@(posedge clk) disable iff (!rst_q)
    clr |=> room || (MAX_BYTES <= 1));
endmodule

// File: rtl/field_ack_unit.sv
module field_ack_unit
  import field_ack_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int LEN_W     = 8,
  parameter int ID_W      = 4,
  parameter int MAX_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fld_vld,
  input  logic [1:0]        fld_kind,
  input  logic [DATA_W-1:0] fld_bits,
  input  logic              fld_par,
  input  logic              tim_err,
  input  logic              rx_empty,
  input  logic              rx_full,
  input  logic              tx_empty,
  input  logic              locked,
  input  logic [ID_W-1:0]   lock_owner,
  input  logic [ID_W-1:0]   cur_master,
  output logic              ack_vld,
  output logic              ack_ok,
  output logic              abort
);
  logic [1:0] rst_ff;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_q = rst_ff[1];

  fkind_e kind;
  assign kind = fkind_e'(fld_kind);

  logic cmd_bad, len_bad, dat_bad, cmd_rej, room;

  field_parity #(.W(CODE_W)) u_par_cmd (
    .bits(fld_bits[CODE_W-1:0]), .par(fld_par), .bad(cmd_bad));
  field_parity #(.W(LEN_W)) u_par_len (
    .bits(fld_bits[LEN_W-1:0]), .par(fld_par), .bad(len_bad));
  field_parity #(.W(DATA_W)) u_par_dat (
    .bits(fld_bits), .par(fld_par), .bad(dat_bad));

  cmd_judge #(.ID_W(ID_W)) u_cmd (
    .code(fld_bits[CODE_W-1:0]), .rx_empty(rx_empty), .tx_empty(tx_empty),
    .locked(locked), .lock_owner(lock_owner), .cur_master(cur_master),
    .reject(cmd_rej));

  logic resp, is_cmd, is_dat;
  assign resp   = fld_vld && (kind != FK_NONE);
  assign is_cmd = resp && (kind == FK_CMD);
  assign is_dat = resp && (kind == FK_DATA);

  byte_budget #(.MAX_BYTES(MAX_BYTES)) u_budget (
    .clk(clk), .rst_q(rst_q), .clr(is_cmd), .inc(is_dat), .room(room));

  // timing fault memory since the previous answer
  logic tim_q, tim_d, tim_en, tim_any;
  assign tim_any = tim_q || tim_err;

  always_comb begin
    tim_en = resp || tim_err;
    tim_d  = !resp;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q)      tim_q <= 1'b0;
    else if (tim_en) tim_q <= tim_d;
  end

  // decision
  logic nak, stop, vld_d, ok_d, abort_d;

  always_comb begin
    nak  = 1'b0;
    stop = 1'b0;
    unique case (kind)
      FK_CMD: begin
        nak  = cmd_bad || cmd_rej || tim_any;
        stop = nak;
      end
      FK_LEN: begin
        nak  = len_bad || tim_any;
        stop = nak;
      end
      FK_DATA: begin
        nak  = dat_bad || rx_full || tim_any;
        stop = tim_any || (nak && !room);
      end
      default: begin
        nak  = 1'b0;
        stop = 1'b0;
      end
    endcase
    vld_d   = resp;
    ok_d    = resp && !nak;
    abort_d = resp && stop;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ack_vld <= 1'b0;
      ack_ok  <= 1'b0;
      abort   <= 1'b0;
    end else begin
      ack_vld <= vld_d;
      ack_ok  <= ok_d;
      abort   <= abort_d;
    end
  end

  a_r1_answer_follows : assert property (@(posedge clk) disable iff (!rst_q)
    (fld_vld && fld_kind != 2'd3) |=> ack_vld);
  a_r1_no_stray_answer : assert property (@(posedge clk) disable iff (!rst_q)
    !(fld_vld && fld_kind != 2'd3) |=> !ack_vld);
  a_r12_abort_with_nak : assert property (@(posedge clk) disable iff (!rst_q)
    abort |-> (ack_vld && !ack_ok));
  a_r2_cmd_parity_stop : assert property (@(posedge clk) disable iff (!rst_q)
    (fld_vld && fld_kind == 2'd0 && cmd_bad) |=> (!ack_ok && abort));
  a_r8_data_timing_stop : assert property (@(posedge clk) disable iff (!rst_q)
    (fld_vld && fld_kind == 2'd2 && tim_err) |=> abort);
  a_r9_len_clean_ack : assert property (@(posedge clk) disable iff (!rst_q)
    (fld_vld && fld_kind == 2'd1 && !len_bad && !tim_err && !tim_q) |=> ack_ok);
endmodule

// File: tb/field_ack_unit_tb_top.sv
module field_ack_unit_tb_top;
  localparam int DATA_W = 8;
  localparam int ID_W   = 3;
  localparam int MAXB   = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              fld_vld;
  logic [1:0]        fld_kind;
  logic [DATA_W-1:0] fld_bits;
  logic              fld_par;
  logic              tim_err;
  logic              rx_empty, rx_full, tx_empty, locked;
  logic [ID_W-1:0]   lock_owner, cur_master;
  logic              ack_vld, ack_ok, abort;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  field_ack_unit #(.DATA_W(DATA_W), .LEN_W(8), .ID_W(ID_W), .MAX_BYTES(MAXB)) dut_i (
    .clk(clk), .rst_n(rst_n), .fld_vld(fld_vld), .fld_kind(fld_kind),
    .fld_bits(fld_bits), .fld_par(fld_par), .tim_err(tim_err),
    .rx_empty(rx_empty), .rx_full(rx_full), .tx_empty(tx_empty),
    .locked(locked), .lock_owner(lock_owner), .cur_master(cur_master),
    .ack_vld(ack_vld), .ack_ok(ack_ok), .abort(abort));

  typedef struct packed {
    logic [1:0] k;
    logic [7:0] b;
    logic       bad, tm, rxe, rxf, txe, lk;
    logic [2:0] own, cur;
    logic       eack;
    logic [3:0] req;
  } tv_t;

  localparam int NV = 24;
  // {kind, bits, bad parity, tim, rx_empty, rx_full, tx_empty, locked, owner, cur, exp ack, req}
  localparam tv_t TBL [NV] = '{
    {2'd0, 8'h00, 6'b001000, 3'd0, 3'd0, 1'b1, 4'd7},  // R7 code 0 accepted
    {2'd0, 8'h00, 6'b101000, 3'd0, 3'd0, 1'b0, 4'd2},  // R2 bad parity
    {2'd0, 8'h0A, 6'b001000, 3'd0, 3'd0, 1'b1, 4'd3},  // R3 write, rx empty
    {2'd0, 8'h0A, 6'b000000, 3'd0, 3'd0, 1'b0, 4'd3},  // R3 write, rx busy
    {2'd0, 8'h03, 6'b001000, 3'd0, 3'd0, 1'b1, 4'd4},  // R4 read, tx has data
    {2'd0, 8'h07, 6'b001010, 3'd0, 3'd0, 1'b0, 4'd4},  // R4 read, tx empty
    {2'd0, 8'h06, 6'b001010, 3'd0, 3'd0, 1'b1, 4'd4},  // R4 code 6 ignores tx
    {2'd0, 8'h06, 6'b001001, 3'd2, 3'd5, 1'b0, 4'd5},  // R5 foreign master
    {2'd0, 8'h06, 6'b001001, 3'd2, 3'd2, 1'b1, 4'd5},  // R5 owner itself
    {2'd0, 8'h00, 6'b001001, 3'd2, 3'd5, 1'b1, 4'd5},  // R5 code outside set
    {2'd0, 8'h0F, 6'b001001, 3'd1, 3'd3, 1'b0, 4'd5},  // R5 code F foreign
    {2'd0, 8'h04, 6'b001000, 3'd0, 3'd0, 1'b0, 4'd6},  // R6 not locked
    {2'd0, 8'h05, 6'b001001, 3'd1, 3'd1, 1'b1, 4'd6},  // R6 locked
    {2'd0, 8'h04, 6'b001001, 3'd1, 3'd3, 1'b1, 4'd6},  // R6 any master
    {2'd0, 8'h01, 6'b001000, 3'd0, 3'd0, 1'b0, 4'd7},  // R7 undefined 1
    {2'd0, 8'h0C, 6'b001000, 3'd0, 3'd0, 1'b0, 4'd7},  // R7 undefined C
    {2'd0, 8'h09, 6'b001000, 3'd0, 3'd0, 1'b0, 4'd7},  // R7 undefined 9
    {2'd0, 8'h00, 6'b011000, 3'd0, 3'd0, 1'b0, 4'd8},  // R8 timing in cmd
    {2'd1, 8'h55, 6'b000111, 3'd1, 3'd2, 1'b1, 4'd9},  // R9 length ignores state
    {2'd1, 8'h55, 6'b101000, 3'd0, 3'd0, 1'b0, 4'd2},  // R2 length parity
    {2'd1, 8'h12, 6'b011000, 3'd0, 3'd0, 1'b0, 4'd8},  // R8 timing in length
    {2'd0, 8'h0B, 6'b001010, 3'd0, 3'd0, 1'b1, 4'd4},  // R4 code B is no read
    {2'd0, 8'h0E, 6'b000001, 3'd4, 3'd4, 1'b0, 4'd3},  // R3 owner write, rx busy
    {2'd0, 8'h03, 6'b001001, 3'd4, 3'd4, 1'b1, 4'd5}   // R5 owner read
  };

  task automatic strobe(input logic [1:0] k, input logic [7:0] b,
                        input logic bad, input logic tm);
    @(negedge clk);
    fld_vld  = 1'b1;
    fld_kind = k;
    fld_bits = b;
    fld_par  = (k == 2'd0 ? ^b[3:0] : ^b) ^ bad;
    tim_err  = tm;
    @(negedge clk);
    fld_vld = 1'b0;
    tim_err = 1'b0;
  endtask

  task automatic expect_ans(input string tag, input logic ev, input logic eok,
                            input logic eab);
    checks++;
    if (ack_vld !== ev || (ev && ack_ok !== eok) || abort !== eab) begin
      errors++;
      $display("FAIL %s: vld/ok/abort = %b/%b/%b, expected %b/%b/%b",
               tag, ack_vld, ack_ok, abort, ev, eok, eab);
    end
  endtask

  task automatic set_env(input logic rxe, input logic rxf, input logic txe,
                         input logic lk, input logic [2:0] own, input logic [2:0] cur);
    rx_empty = rxe; rx_full = rxf; tx_empty = txe;
    locked = lk; lock_owner = own; cur_master = cur;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fld_vld = 1'b0; fld_kind = 2'd0; fld_bits = '0;
    fld_par = 1'b0; tim_err = 1'b0;
    set_env(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);
    repeat (4) @(negedge clk);
    expect_ans("R1 reset state", 1'b0, 1'b0, 1'b0);
    checks++;
    if (ack_ok !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset ack_ok: %b, expected 0", ack_ok);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      tv_t v;
      v = TBL[i];
      set_env(v.rxe, v.rxf, v.txe, v.lk, v.own, v.cur);
      strobe(v.k, v.b, v.bad, v.tm);
      expect_ans($sformatf("R%0d vector %0d", v.req, i), 1'b1, v.eack, !v.eack);
    end
    set_env(1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0);

    // R1 kind 3 gets no answer
    strobe(2'd3, 8'h00, 1'b0, 1'b0);
    expect_ans("R1 kind 3 silent", 1'b0, 1'b0, 1'b0);

    // R8 remembered timing fault, cleared by the answer
    @(negedge clk); tim_err = 1'b1;
    @(negedge clk); tim_err = 1'b0;
    repeat (2) @(negedge clk);
    strobe(2'd0, 8'h00, 1'b0, 1'b0);
    expect_ans("R8 remembered fault", 1'b1, 1'b0, 1'b1);
    strobe(2'd0, 8'h00, 1'b0, 1'b0);
    expect_ans("R8 memory cleared", 1'b1, 1'b1, 1'b0);

    // R11 repeat budget with parity failures
    strobe(2'd2, 8'h3C, 1'b1, 1'b0);
    expect_ans("R11 byte 1 retry", 1'b1, 1'b0, 1'b0);
    strobe(2'd2, 8'h3C, 1'b1, 1'b0);
    expect_ans("R11 byte 2 retry", 1'b1, 1'b0, 1'b0);
    strobe(2'd2, 8'h3C, 1'b1, 1'b0);
    expect_ans("R11 byte 3 retry", 1'b1, 1'b0, 1'b0);
    strobe(2'd2, 8'h3C, 1'b1, 1'b0);
    expect_ans("R11 byte 4 budget spent", 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    expect_ans("R12 abort one clock", 1'b0, 1'b0, 1'b0);

    // R10 full buffer, R8 timing on data, R11 saturation
    strobe(2'd0, 8'h00, 1'b0, 1'b0);
    expect_ans("R11 command resets count", 1'b1, 1'b1, 1'b0);
    rx_full = 1'b1;
    strobe(2'd2, 8'hA5, 1'b0, 1'b0);
    expect_ans("R10 full buffer", 1'b1, 1'b0, 1'b0);
    rx_full = 1'b0;
    strobe(2'd2, 8'hA5, 1'b0, 1'b0);
    expect_ans("R10 room again", 1'b1, 1'b1, 1'b0);
    strobe(2'd2, 8'hA5, 1'b0, 1'b1);
    expect_ans("R8 data timing stops", 1'b1, 1'b0, 1'b1);
    strobe(2'd2, 8'h81, 1'b0, 1'b0);
    expect_ans("R12 ack without abort", 1'b1, 1'b1, 1'b0);
    strobe(2'd2, 8'h81, 1'b1, 1'b0);
    expect_ans("R11 saturated count stops", 1'b1, 1'b0, 1'b1);
    strobe(2'd0, 8'h00, 1'b0, 1'b0);
    expect_ans("R7 code 0 again", 1'b1, 1'b1, 1'b0);
    strobe(2'd2, 8'h81, 1'b1, 1'b0);
    expect_ans("R11 fresh frame retry", 1'b1, 1'b0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule